// File: doc/BRIEF.md
# Receive Pop and Status Interface

This block sits between a byte-wide frame receiver and a processor core that reads the received data in its own time. Incoming bytes go into a small receive FIFO. The core sees the oldest two bytes through a 16-bit read register, together with a byte-ready flag and a word-ready flag. The core moves through the stream with one-cycle pop pulses. A 1-byte pop consumes one byte and a 2-byte pop consumes two. The read register then reloads exactly two cycles later.

Alongside the data path, the block keeps sticky flags for start of frame, delimiter seen, end of frame, receive error and FIFO overrun. Each frame flag has its own write-one clear command. A flush command empties the FIFO. When the flush comes in the middle of a frame, the rest of that frame is thrown away until the next start of frame. Commands arrive as a 16-bit vector of single-cycle pulses, and index i of that vector stands for command bit 16+i.

Top module: `rx_pop_status`

## Requirements
- R1: After reset, rd_data is 0, byte_rdy and word_rdy are 0, and every status flag, including st_ovf, is 0.
- R2: A pulse on cmd[0] (1-byte pop) removes the oldest FIFO byte, or nothing if the FIFO is empty. After the reload, rd_data[7:0] holds the new oldest byte and byte_rdy is 1 whenever at least one byte remains.
- R3: A pulse on cmd[1] (2-byte pop) removes the two oldest bytes, or as many as are present, and takes precedence over cmd[0]. After the reload, rd_data holds {second-oldest, oldest} and word_rdy is 1 whenever at least two bytes remain. word_rdy implies byte_rdy.
- R4: Once the read register holds two bytes, rd_data and both ready flags keep their values until the next pop or flush. Later arrivals do not change them. While it holds fewer than two bytes, including after reset, it picks up newly arrived bytes one cycle after each write.
- R5: On the edge that samples a pop, both ready flags drop to 0. On the next edge, the read register and the flags take the reloaded values.
- R6: st_sof is set by a byte with in_sof, st_sfd by a pulse on in_sfd, st_eof by an accepted byte with in_eof, and st_err by a pulse on in_err. Each flag stays set until it is cleared.
- R7: cmd[7] clears st_err, cmd[6] clears st_eof, cmd[5] clears st_sfd and cmd[4] clears st_sof, one edge after the pulse. cmd[3] is reserved and has no effect on any output.
- R8: When a set event and the clear command for the same flag occur in the same cycle, the flag ends up set.
- R9: cmd[2] (flush) empties the FIFO, clears st_ovf, sets rd_data to 0 and drops both ready flags on the next edge. It leaves the frame flags unchanged.
- R10: A flush while a frame is open (start of frame seen, no end yet) discards every later byte until one arrives with in_sof. That byte is accepted.
- R11: A byte that arrives while the FIFO holds DEPTH bytes is dropped and sets st_ovf, which stays set until a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receiver byte strobe |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_sfd | input | 1 | Delimiter-seen pulse |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Receive error pulse |
| cmd | input | 16 | Command pulses, index i = command bit 16+i |
| rd_data | output | 16 | Read register {second-oldest, oldest} |
| byte_rdy | output | 1 | rd_data[7:0] valid |
| word_rdy | output | 1 | rd_data[15:0] valid |
| st_sof | output | 1 | Sticky start-of-frame flag |
| st_sfd | output | 1 | Sticky delimiter-seen flag |
| st_eof | output | 1 | Sticky end-of-frame flag |
| st_err | output | 1 | Sticky receive-error flag |
| st_ovf | output | 1 | Sticky FIFO overrun flag |

## Verification
Status flags and flush effects are due one edge after their stimulus. A pop produces two results: the ready flags are 0 one edge after it, and the reloaded data and flags appear one edge later. A written byte reaches a read register that is still filling two edges after the write is driven. Stimulus is driven on falling edges and each result is sampled on the falling edge that matches its latency. The zero-flag window after a pop is therefore checked separately from the reloaded value.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  // command vector indices (index i = command bit 16+i)
  localparam int CMD_W      = 16;
  localparam int C_POP8     = 0;
  localparam int C_POP16    = 1;
  localparam int C_FLUSH    = 2;
  localparam int C_RSVD     = 3;
  localparam int C_CLR_SOF  = 4;
  localparam int C_CLR_SFD  = 5;
  localparam int C_CLR_EOF  = 6;
  localparam int C_CLR_ERR  = 7;
  // status flag positions
  localparam int NFLAG      = 4;
  localparam int F_SOF      = 0;
  localparam int F_SFD      = 1;
  localparam int F_EOF      = 2;
  localparam int F_ERR      = 3;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxp_byte_fifo.sv
module rxp_byte_fifo #(
  parameter int DEPTH = 8,  // power of two, at least 2
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic [1:0]                   pop_n,
  output logic [DW-1:0]                head0,
  output logic [DW-1:0]                head1,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf_ev
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_nx;
  logic          full, wr_ok;

  assign full   = (count == CW'(DEPTH));
  assign wr_ok  = wr_en && !flush && !full;
  assign ovf_ev = wr_en && !flush && full;
  assign rd_nx  = rd_ptr + AW'(1);

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[rd_nx];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(wr_ok) - CW'(pop_n);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R11
  AST_POP_WITHIN: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= count); // R2
endmodule

// File: rtl/rxp_frame_gate.sv
module rxp_frame_gate (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  output logic acc,
  output logic sof_ev,
  output logic eof_ev,
  output logic drop
);
  logic in_frame, discard;

  assign discard = drop && !(in_valid && in_sof);
  assign acc     = in_valid && !discard;
  assign sof_ev  = in_valid && in_sof;
  assign eof_ev  = acc && in_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      drop     <= 1'b0;
    end else if (flush) begin
      in_frame <= 1'b0;
      drop     <= in_frame || (in_valid && in_sof && !in_eof);
    end else begin
      if (in_valid && in_sof) drop <= 1'b0;
      if (acc && in_sof && !in_eof)   in_frame <= 1'b1;
      else if (acc && in_eof)         in_frame <= 1'b0;
    end
  end

  AST_SOF_REOPENS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !flush) |=> !drop); // R10
endmodule

// File: rtl/rxp_sticky.sv
module rxp_sticky
  import rxp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t ev,
  input  flag_vec_t clr,
  input  logic      ovf_ev,
  input  logic      flush,
  output flag_vec_t st,
  output logic      ovf
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)         f_q <= 1'b0;
      else if (ev[i])  f_q <= 1'b1;  // hardware event beats clear
      else if (clr[i]) f_q <= 1'b0;
    end
    assign st[i] = f_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> st[i]); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !ev[i]) |=> !st[i]); // R7
  end

  always_ff @(posedge clk) begin
    if (rst || flush) ovf <= 1'b0;
    else if (ovf_ev)  ovf <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush) |=> ovf); // R11
endmodule

// File: rtl/rxp_read_port.sv
module rxp_read_port #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            pop8,
  input  logic            pop16,
  input  logic [DW-1:0]   head0,
  input  logic [DW-1:0]   head1,
  input  logic [CW-1:0]   count,
  output logic [1:0]      pop_n,
  output logic [2*DW-1:0] rd_data,
  output logic            byte_rdy,
  output logic            word_rdy
);
  logic       armed;
  logic       pop_any;
  logic       has1, has2;
  logic [1:0] want;

  assign pop_any = pop8 || pop16;
  assign has1    = (count >= CW'(1));
  assign has2    = (count >= CW'(2));
  assign want    = pop16 ? 2'd2 : (pop8 ? 2'd1 : 2'd0);

  always_comb begin
    if (has2)      pop_n = want;
    else if (has1) pop_n = (want != 2'd0) ? 2'd1 : 2'd0;
    else           pop_n = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      armed    <= 1'b1;
      byte_rdy <= 1'b0;
      word_rdy <= 1'b0;
      rd_data  <= '0;
    end else if (pop_any) begin
      armed    <= 1'b1;
      byte_rdy <= 1'b0;
      word_rdy <= 1'b0;
    end else if (armed) begin
      byte_rdy <= has1;
      word_rdy <= has2;
      rd_data  <= {has2 ? head1 : {DW{1'b0}}, has1 ? head0 : {DW{1'b0}}};
      if (has2) armed <= 1'b0;
    end
  end

  AST_FLAGS_LOW_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    pop_any |=> (!byte_rdy && !word_rdy)); // R5
  AST_WORD_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    word_rdy |-> byte_rdy); // R3
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (word_rdy && !pop_any && !flush) |=> ($stable(rd_data) && word_rdy)); // R4
endmodule

// File: rtl/rx_pop_status.sv
module rx_pop_status
  import rxp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            in_sof,
  input  logic            in_sfd,
  input  logic            in_eof,
  input  logic            in_err,
  input  logic [CMD_W-1:0] cmd,
  output logic [2*DW-1:0] rd_data,
  output logic            byte_rdy,
  output logic            word_rdy,
  output logic            st_sof,
  output logic            st_sfd,
  output logic            st_eof,
  output logic            st_err,
  output logic            st_ovf
);
  localparam int CW = $clog2(DEPTH+1);

  logic          flush, acc, sof_ev, eof_ev, drop, ovf_ev;
  logic [1:0]    pop_n;
  logic [DW-1:0] head0, head1;
  logic [CW-1:0] count;
  flag_vec_t     ev, clr, st;
  logic          unused_cmd;

  assign flush      = cmd[C_FLUSH];
  assign unused_cmd = ^{cmd[CMD_W-1:C_CLR_ERR+1], cmd[C_RSVD]};

  rxp_frame_gate u_gate (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .acc(acc), .sof_ev(sof_ev),
    .eof_ev(eof_ev), .drop(drop)
  );

  rxp_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(acc), .wr_data(in_data),
    .pop_n(pop_n), .head0(head0), .head1(head1), .count(count),
    .ovf_ev(ovf_ev)
  );

  rxp_read_port #(.DW(DW), .CW(CW)) u_read (
    .clk(clk), .rst(rst), .flush(flush), .pop8(cmd[C_POP8]),
    .pop16(cmd[C_POP16]), .head0(head0), .head1(head1), .count(count),
    .pop_n(pop_n), .rd_data(rd_data), .byte_rdy(byte_rdy),
    .word_rdy(word_rdy)
  );

  always_comb begin
    ev        = '0;
    ev[F_SOF] = sof_ev;
    ev[F_SFD] = in_sfd;
    ev[F_EOF] = eof_ev;
    ev[F_ERR] = in_err;
    clr        = '0;
    clr[F_SOF] = cmd[C_CLR_SOF];
    clr[F_SFD] = cmd[C_CLR_SFD];
    clr[F_EOF] = cmd[C_CLR_EOF];
    clr[F_ERR] = cmd[C_CLR_ERR];
  end

  rxp_sticky u_sticky (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .ovf_ev(ovf_ev),
    .flush(flush), .st(st), .ovf(st_ovf)
  );

  assign st_sof = st[F_SOF];
  assign st_sfd = st[F_SFD];
  assign st_eof = st[F_EOF];
  assign st_err = st[F_ERR];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !byte_rdy)); // R9
  AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (drop && in_valid && !in_sof && !flush && pop_n == 2'd0)
      |=> (count == $past(count))); // R10
endmodule

// File: tb/rx_pop_status_tb_top.sv
module rx_pop_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_sfd = 1'b0;
  logic        in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] cmd = '0;
  logic [15:0] rd_data;
  logic        byte_rdy, word_rdy, st_sof, st_sfd, st_eof, st_err, st_ovf;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pop_status #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_sfd(in_sfd), .in_eof(in_eof), .in_err(in_err),
    .cmd(cmd), .rd_data(rd_data), .byte_rdy(byte_rdy), .word_rdy(word_rdy),
    .st_sof(st_sof), .st_sfd(st_sfd), .st_eof(st_eof), .st_err(st_err),
    .st_ovf(st_ovf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic sof, logic eof);
    in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic pulse_cmd(logic [15:0] bits);
    cmd = bits;
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flags", {byte_rdy, word_rdy}, 0);
    chk("R1 status", {st_sof, st_sfd, st_eof, st_err, st_ovf}, 0);
  endtask

  task automatic t_fill;
    push(8'hA1, 1'b1, 1'b0); idle(1);
    chk("R4 first byte", {byte_rdy, word_rdy, rd_data[7:0]}, {2'b10, 8'hA1});
    chk("R6 sof set", st_sof, 1);
    push(8'hA2, 1'b0, 1'b0); idle(1);
    chk("R3 word ready", {word_rdy, rd_data}, {1'b1, 16'hA2A1});
    push(8'hA3, 1'b0, 1'b0); push(8'hA4, 1'b0, 1'b0); idle(2);
    chk("R4 hold", {word_rdy, rd_data}, {1'b1, 16'hA2A1});
  endtask

  task automatic t_pop16;
    pulse_cmd(16'h0002);
    chk("R5 flags low", {byte_rdy, word_rdy}, 0);
    idle(1);
    chk("R3 pop16 reload", {byte_rdy, word_rdy, rd_data}, {2'b11, 16'hA4A3});
  endtask

  task automatic t_pop8;
    push(8'hB1, 1'b0, 1'b0);
    pulse_cmd(16'h0001);
    chk("R5 flags low pop8", {byte_rdy, word_rdy}, 0);
    idle(1);
    chk("R2 pop8 reload", {word_rdy, rd_data}, {1'b1, 16'hB1A4});
    pulse_cmd(16'h0002); idle(1);
    chk("R3 empty after pop16", {byte_rdy, word_rdy}, 0);
    push(8'hB2, 1'b0, 1'b0); idle(1);
    chk("R2 refill byte", {byte_rdy, word_rdy, rd_data[7:0]}, {2'b10, 8'hB2});
    pulse_cmd(16'h0001); idle(1);
    chk("R2 pop8 to empty", {byte_rdy, word_rdy}, 0);
  endtask

  task automatic t_status;
    in_sfd = 1'b1; @(negedge clk); in_sfd = 1'b0;
    chk("R6 sfd", st_sfd, 1);
    in_err = 1'b1; @(negedge clk); in_err = 1'b0;
    chk("R6 err", st_err, 1);
    push(8'hC9, 1'b0, 1'b1);
    chk("R6 eof", st_eof, 1);
    idle(1);
    pulse_cmd(16'h0008); idle(1);
    chk("R7 reserved no effect",
        {st_sof, st_sfd, st_eof, st_err, byte_rdy, rd_data[7:0]},
        {4'b1111, 1'b1, 8'hC9});
    pulse_cmd(16'h0010);
    chk("R7 clear sof", {st_sof, st_sfd, st_eof, st_err}, 4'b0111);
    pulse_cmd(16'h0020);
    chk("R7 clear sfd", {st_sfd, st_eof, st_err}, 3'b011);
    pulse_cmd(16'h0040);
    chk("R7 clear eof", {st_eof, st_err}, 2'b01);
    in_err = 1'b1; cmd = 16'h0080; @(negedge clk); in_err = 1'b0; cmd = '0;
    chk("R8 set beats clear", st_err, 1);
    pulse_cmd(16'h0080);
    chk("R7 clear err", st_err, 0);
  endtask

  task automatic t_ovf;
    pulse_cmd(16'h0004); idle(1);
    for (int i = 0; i <= DEPTH; i++) push(8'hD0 + 8'(i), i == 0, 1'b0);
    chk("R11 overrun set", st_ovf, 1);
    chk("R4 holds first pair", rd_data, 16'hD1D0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      pulse_cmd(16'h0001); idle(1);
    end
    chk("R11 last kept byte", {byte_rdy, word_rdy, rd_data[7:0]},
        {2'b10, 8'hD0 + 8'(DEPTH - 1)});
    pulse_cmd(16'h0001); idle(1);
    chk("R11 dropped byte absent", byte_rdy, 0);
  endtask

  task automatic t_flush_midframe;
    push(8'hE0, 1'b0, 1'b0); idle(1);
    chk("R10 pre-flush byte", byte_rdy, 1);
    pulse_cmd(16'h0004);
    chk("R9 flush", {byte_rdy, word_rdy, st_ovf, rd_data}, 0);
    chk("R9 frame flags kept", {st_sof, st_err}, 2'b10);
    push(8'hE1, 1'b0, 1'b0); push(8'hE2, 1'b0, 1'b0); idle(2);
    chk("R10 discarded", byte_rdy, 0);
    push(8'hF0, 1'b1, 1'b0); idle(1);
    chk("R10 resume on sof", {byte_rdy, rd_data[7:0]}, {1'b1, 8'hF0});
    push(8'hF1, 1'b0, 1'b0); idle(1);
    chk("R10 frame continues", {word_rdy, rd_data}, {1'b1, 16'hF1F0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_pop16();
    t_pop8();
    t_status();
    t_ovf();
    t_flush_midframe();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule